// File: doc/BRIEF.md
# Timer Mode Control with Overflow Detection

This block is an up-counting timer governed by an eight-bit mode control register. The register can be written as a whole byte, or one bit at a time through an index/value/strobe interface. It reads back continuously. The register carries four things: a unit enable that holds the whole unit in reset while low, a count enable, a three-bit prescaler select, and a sticky overflow flag.

The counter is `CNT_W` bits wide, 16 by default. It steps once per prescaled tick. When it wraps from all-ones to zero, the block raises a one-cycle overflow interrupt pulse and sets the flag in the same cycle.

A wrap that is really a compare-match clear does not count as an overflow. Compare mode, clear-on-match and the compare value arrive as plain inputs. When software writes the flag in the same cycle as a hardware overflow, the written value wins. The interrupt pulse is still produced, and it never depends on the flag.

Top module: `tmr_ctl_unit`

## Requirements
- R1: After reset the control register reads 00h, the counter reads 0 and the overflow interrupt is low.
- R2: Register layout: bit 7 is the overflow flag, bits 6..4 the prescaler select, bit 1 the count enable and bit 0 the unit enable. While the unit enable is 1, a byte write replaces every writable bit, and a bit write (index `bit_idx`, value `bit_val`) changes only the addressed bit.
- R3: While the unit enable reads 0, a write can change only bit 0. Writing bit 0 to 0 returns every bit to 0 at once and clears the counter one cycle later.
- R4: Bits 3..2 always read 0. Writes of 1 to them are discarded.
- R5: The counter advances only while the count enable is 1, once per tick. A select value k gives a tick every 2^k cycles, with the prescaler restarting when counting is enabled. After the edge that enables counting, the counter holds floor(j / 2^k) after j further clock edges.
- R6: A step from all-ones to 0 sets the overflow flag and drives `ovf_irq` high for exactly one cycle. Both become visible after the same clock edge.
- R7: With `cmp_mode` and `clr_on_match` both 1, a tick at which the counter equals `cmp_val` loads 0 instead of incrementing. When `cmp_val` is all-ones, that clear neither sets the flag nor pulses `ovf_irq`. With `cmp_mode` at 0, no clear happens.
- R8: Once set, the flag stays 1 until software writes 0 to bit 7 or the unit enable is cleared.
- R9: A write that addresses bit 7 in the same cycle as an overflow leaves the flag at the written value, and `ovf_irq` still pulses. A bit write to any other index does not block the hardware set.
- R10: A software write of 1 to the flag produces no interrupt pulse.
- R11: When `byte_we` and `bit_we` are both high in one cycle, only the byte write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_we | input | 1 | Byte write strobe |
| byte_wdata | input | 8 | Byte write data |
| bit_we | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Index of the bit to write |
| bit_val | input | 1 | Value for the single-bit write |
| cmp_mode | input | 1 | Compare mode select |
| clr_on_match | input | 1 | Clear counter on compare match |
| cmp_val | input | CNT_W | Compare value |
| ctl_rdata | output | 8 | Control register read value |
| count | output | CNT_W | Current counter value |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
A corrupted field in the control register shows up on `ctl_rdata` one cycle after the write that caused it, because the register is read back continuously. A wrong prescaler phase or a wrong tap shows as a counter value off by one at the exact cycle where a step is predicted. A misjudged wrap shows in the cycle right after the counter reads all-ones: the flag or the interrupt is missing, or it appears during a compare clear. Because the flag and the pulse are separate outputs, a flag that hides or creates a pulse is caught in that same cycle.

// File: rtl/tmr_pkg.sv
// Package: shared field positions and the control register image type.
// Assumes the eight-bit register layout fixed by the requirements.
package tmr_pkg;
    localparam int SEL_W    = 3;
    localparam int OVF_BIT  = 7;
    localparam int SEL_LSB  = 4;
    localparam int CEN_BIT  = 1;
    localparam int UE_BIT   = 0;

    typedef struct packed {
        logic             ovf;
        logic [SEL_W-1:0] sel;
        logic             cen;
        logic             ue;
    } tmr_ctl_t;
endpackage

// File: rtl/tmr_ctl_reg.sv
// Module: control register. Merges byte and bit writes into one image,
// applies the unit-enable gating and resolves a flag write against a
// hardware overflow set. Assumes hw_ovf is only raised while ue is 1.
module tmr_ctl_reg
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_we,
    input  logic [7:0] byte_wdata,
    input  logic       bit_we,
    input  logic [2:0] bit_idx,
    input  logic       bit_val,
    input  logic       hw_ovf,
    output tmr_ctl_t   ctl,
    output logic [7:0] rdata
);
    tmr_ctl_t   ctl_q;
    tmr_ctl_t   ctl_d;
    logic [7:0] cur_img;
    logic [7:0] wr_img;
    logic       wr_any;
    logic       flag_wr;

    // Purpose: build the current readable image with reserved bits forced low.
    always_comb begin
        cur_img                         = '0;
        cur_img[OVF_BIT]                = ctl_q.ovf;
        cur_img[SEL_LSB +: SEL_W]       = ctl_q.sel;
        cur_img[CEN_BIT]                = ctl_q.cen;
        cur_img[UE_BIT]                 = ctl_q.ue;
    end

    // Purpose: form the write image; a byte write wins over a bit write.
    always_comb begin
        wr_img = cur_img;
        if (byte_we) begin
            wr_img = byte_wdata;
        end else if (bit_we) begin
            wr_img[bit_idx] = bit_val;
        end
        wr_any  = byte_we | bit_we;
        flag_wr = byte_we | (bit_we && (bit_idx == 3'(OVF_BIT)));
    end

    // Purpose: next-state rules for gating, clearing, hardware set and conflict.
    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.ue && hw_ovf) begin
            ctl_d.ovf = 1'b1;
        end
        if (wr_any) begin
            if (!ctl_q.ue) begin
                ctl_d    = '0;
                ctl_d.ue = wr_img[UE_BIT];
            end else if (!wr_img[UE_BIT]) begin
                ctl_d = '0;
            end else begin
                ctl_d.sel = wr_img[SEL_LSB +: SEL_W];
                ctl_d.cen = wr_img[CEN_BIT];
                if (flag_wr) begin
                    ctl_d.ovf = wr_img[OVF_BIT];
                end
            end
        end
    end

    // Purpose: hold the register state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl   = ctl_q;
    assign rdata = cur_img;
endmodule

// File: rtl/tmr_prescaler.sv
// Module: prescaler. Divides the clock by 2**sel and emits a one-cycle tick.
// Assumes it restarts from zero whenever counting is disabled or the unit is off.
module tmr_prescaler #(
    parameter int SEL_W = 3,
    localparam int PRE_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // One mask bit per prescaler stage, set when the select reaches past it.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (32'(sel) > i);
    end

    // Purpose: free-running divider, cleared while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && ((pre_q & mask) == mask);
endmodule

// File: rtl/tmr_counter.sv
// Module: the counter with its compare-clear and wrap detection.
// Assumes the tick only arrives while counting is enabled.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_en,
    input  logic             tick,
    input  logic             cmp_mode,
    input  logic             clr_on_match,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt,
    output logic             ovf_irq
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             clr_hit;

    // Purpose: decide between a compare clear and a true wrap for this tick.
    always_comb begin
        clr_hit  = tick && cmp_mode && clr_on_match && (cnt_q == cmp_val);
        wrap_evt = tick && !clr_hit && (cnt_q == ALL_ONES);
    end

    // Purpose: count register, held in reset while the unit is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !unit_en) begin
            cnt_q <= '0;
        end else if (clr_hit) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: one-cycle interrupt pulse aligned with the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n || !unit_en) begin
            ovf_irq <= 1'b0;
        end else begin
            ovf_irq <= wrap_evt;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/tmr_ctl_unit.sv
// Module: top of the timer. Connects the control register, the prescaler
// and the counter. Assumes a single clock domain and synchronous reset.
module tmr_ctl_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_we,
    input  logic [7:0]       byte_wdata,
    input  logic             bit_we,
    input  logic [2:0]       bit_idx,
    input  logic             bit_val,
    input  logic             cmp_mode,
    input  logic             clr_on_match,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [7:0]       ctl_rdata,
    output logic [CNT_W-1:0] count,
    output logic             ovf_irq
);
    tmr_ctl_t ctl;
    logic     tick;
    logic     wrap_evt;

    tmr_ctl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_we    (byte_we),
        .byte_wdata (byte_wdata),
        .bit_we     (bit_we),
        .bit_idx    (bit_idx),
        .bit_val    (bit_val),
        .hw_ovf     (wrap_evt),
        .ctl        (ctl),
        .rdata      (ctl_rdata)
    );

    tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl.ue && ctl.cen),
        .sel   (ctl.sel),
        .tick  (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .unit_en      (ctl.ue),
        .tick         (tick),
        .cmp_mode     (cmp_mode),
        .clr_on_match (clr_on_match),
        .cmp_val      (cmp_val),
        .count        (count),
        .wrap_evt     (wrap_evt),
        .ovf_irq      (ovf_irq)
    );
endmodule

// File: rtl/tmr_ctl_chk.sv
// Module: property checker for the timer, attached to the top by bind.
// Observes ports only and keeps a few registered copies of past inputs.
module tmr_ctl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_we,
    input logic             wdat7,
    input logic             bit_we,
    input logic [2:0]       bit_idx,
    input logic             bit_val,
    input logic             cmp_mode,
    input logic             clr_on_match,
    input logic [CNT_W-1:0] cmp_val,
    input logic [7:0]       ctl_rdata,
    input logic [CNT_W-1:0] count,
    input logic             ovf_irq
);
    logic prev_wr7;
    logic prev_w7val;
    logic prev_flag;
    logic prev_sup;

    // Purpose: remember last-cycle flag writes and the suppression condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_wr7   <= 1'b0;
            prev_w7val <= 1'b0;
            prev_flag  <= 1'b0;
            prev_sup   <= 1'b0;
        end else begin
            prev_wr7   <= byte_we || (bit_we && bit_idx == 3'd7);
            prev_w7val <= byte_we ? wdat7 : bit_val;
            prev_flag  <= ctl_rdata[7];
            prev_sup   <= cmp_mode && clr_on_match && (&cmp_val);
        end
    end

    assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[3:2] == 2'b00);

    assert_off_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |-> ctl_rdata[7:1] == 7'd0);

    assert_off_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[0] |=> count == '0);

    assert_hold_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[0] && !ctl_rdata[1]) |=> $stable(count));

    assert_irq_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> count == '0);

    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |=> !ovf_irq);

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq && !prev_wr7 && ctl_rdata[0]) |-> ctl_rdata[7]);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prev_sup |-> !ovf_irq);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_flag && !prev_wr7 && ctl_rdata[0]) |-> ctl_rdata[7]);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq && prev_wr7 && ctl_rdata[0]) |-> ctl_rdata[7] == prev_w7val);
endmodule

bind tmr_ctl_unit tmr_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_we      (byte_we),
    .wdat7        (byte_wdata[7]),
    .bit_we       (bit_we),
    .bit_idx      (bit_idx),
    .bit_val      (bit_val),
    .cmp_mode     (cmp_mode),
    .clr_on_match (clr_on_match),
    .cmp_val      (cmp_val),
    .ctl_rdata    (ctl_rdata),
    .count        (count),
    .ovf_irq      (ovf_irq)
);

// File: tb/tmr_ctl_unit_bench.sv
// Bench: directed scenarios, one task each, checked at the ports.
module tmr_ctl_unit_bench;
    localparam int CNT_W = 10;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             byte_we = 1'b0;
    logic [7:0]       byte_wdata = '0;
    logic             bit_we = 1'b0;
    logic [2:0]       bit_idx = '0;
    logic             bit_val = 1'b0;
    logic             cmp_mode = 1'b0;
    logic             clr_on_match = 1'b0;
    logic [CNT_W-1:0] cmp_val = '0;
    logic [7:0]       ctl_rdata;
    logic [CNT_W-1:0] count;
    logic             ovf_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_ctl_unit #(.CNT_W(CNT_W)) u_tmr_ctl_unit (.*);

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        byte_we = 1'b1; byte_wdata = d;
        step();
        byte_we = 1'b0;
    endtask

    task automatic wr_bit(input int idx, input logic v);
        bit_we = 1'b1; bit_idx = 3'(idx); bit_val = v;
        step();
        bit_we = 1'b0;
    endtask

    task automatic wait_count(input logic [CNT_W-1:0] v);
        for (int i = 0; i < 5000 && count != v; i++) step();
        chk("wait", int'(count), int'(v));
    endtask

    task automatic restart(input logic [7:0] mode);
        wr_byte(8'h00); step(); wr_byte(8'h01); wr_byte(mode);
    endtask

    task automatic t_reset();
        chk("R1 rdata", ctl_rdata, 8'h00);
        chk("R1 count", int'(count), 0);
        chk("R1 irq", ovf_irq, 0);
    endtask

    task automatic t_gate_layout();
        wr_byte(8'hF2);   chk("R3 byte ignored", ctl_rdata, 8'h00);
        wr_bit(1, 1'b1);  chk("R3 bit ignored", ctl_rdata, 8'h00);
        wr_byte(8'h01);   chk("R3 enable alone", ctl_rdata, 8'h01);
        wr_byte(8'hBD);   chk("R2 R4 byte", ctl_rdata, 8'hB1);
        wr_bit(2, 1'b1);  chk("R4 rsvd bit", ctl_rdata, 8'hB1);
        wr_bit(7, 1'b0);  chk("R2 bit7", ctl_rdata, 8'h31);
        wr_bit(6, 1'b1);  chk("R2 bit6", ctl_rdata, 8'h71);
        wr_bit(4, 1'b0);  chk("R2 bit4", ctl_rdata, 8'h61);
        byte_we = 1'b1; byte_wdata = 8'h01; bit_we = 1'b1; bit_idx = 3'd1; bit_val = 1'b1;
        step();
        byte_we = 1'b0; bit_we = 1'b0;
        chk("R11 byte wins", ctl_rdata, 8'h01);
    endtask

    task automatic t_ue_clear();
        wr_byte(8'h83);
        repeat (5) step();
        wr_byte(8'h00);
        chk("R3 clear rdata", ctl_rdata, 8'h00);
        step();
        chk("R3 clear count", int'(count), 0);
    endtask

    task automatic t_prescale(input int k);
        int per;
        per = 1 << k;
        restart(8'(8'h03 | (k << 4)));
        repeat (3 * per - 1) step();
        chk("R5 before tick", int'(count), 2);
        step();
        chk("R5 at tick", int'(count), 3);
    endtask

    task automatic t_hold();
        int c0;
        wr_bit(1, 1'b0);
        c0 = int'(count);
        repeat (20) step();
        chk("R5 hold", int'(count), c0);
    endtask

    task automatic t_wrap();
        restart(8'h03);
        wait_count(MAXV);
        chk("R6 pre irq", ovf_irq, 0);
        step();
        chk("R6 count", int'(count), 0);
        chk("R6 irq", ovf_irq, 1);
        chk("R6 flag", ctl_rdata[7], 1);
        step();
        chk("R6 irq one cycle", ovf_irq, 0);
        repeat (50) step();
        chk("R8 sticky", ctl_rdata[7], 1);
        wr_bit(7, 1'b0);
        chk("R8 sw clear", ctl_rdata[7], 0);
    endtask

    task automatic t_sw_flag();
        wr_bit(7, 1'b1);
        chk("R10 flag set", ctl_rdata[7], 1);
        chk("R10 no irq", ovf_irq, 0);
        step();
        chk("R10 no irq later", ovf_irq, 0);
        wr_byte(8'h00);
        chk("R8 ue clears flag", ctl_rdata[7], 0);
    endtask

    task automatic t_conflict();
        restart(8'h03);
        wait_count(MAXV);
        wr_byte(8'h03);
        chk("R9 byte wins flag", ctl_rdata[7], 0);
        chk("R9 irq kept", ovf_irq, 1);
        wait_count(MAXV);
        wr_bit(1, 1'b1);
        chk("R9 other bit", ctl_rdata[7], 1);
        wait_count(MAXV);
        wr_bit(7, 1'b0);
        chk("R9 bit7 wins", ctl_rdata[7], 0);
        chk("R9 irq bit", ovf_irq, 1);
    endtask

    task automatic t_compare();
        cmp_mode = 1'b1; clr_on_match = 1'b1; cmp_val = 10'd5;
        restart(8'h03);
        wait_count(10'd5);
        step();
        chk("R7 clear", int'(count), 0);
        chk("R7 clear no irq", ovf_irq, 0);
        cmp_val = MAXV;
        wait_count(MAXV);
        step();
        chk("R7 ones clear", int'(count), 0);
        chk("R7 ones irq", ovf_irq, 0);
        chk("R7 ones flag", ctl_rdata[7], 0);
        cmp_mode = 1'b0; cmp_val = 10'd5;
        wait_count(10'd5);
        step();
        chk("R7 mode off", int'(count), 6);
        clr_on_match = 1'b0;
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_gate_layout();
        t_ue_clear();
        t_prescale(0);
        t_prescale(2);
        t_prescale(7);
        t_hold();
        t_wrap();
        t_sw_flag();
        t_conflict();
        t_compare();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule